// File: doc/BRIEF.md
# SAR Conversion Control Sequencer

This block models, in one synchronous clock domain, the digital control of a successive-approximation converter. It watches an active-low chip select and a conversion-start strobe. From their edges it decides when the converter samples, when it converts and when a conversion is cut short. A sample strobe marks the sampling window. A busy flag covers the conversion. During the conversion an internal sequencer resolves the result one bit at a time, most significant bit first, against a single comparator bit supplied from outside.

Both control inputs must already be synchronous to `clk`. The block finds edges by comparing each input with a registered copy of itself. A finished conversion writes a straight-binary word into the result register and pulses `result_valid` for one cycle. An abort writes a fixed marker code instead. Between these updates the result register holds its value, so software can read the previous result while the next conversion runs.

Top module: `sar_seq`

## Requirements
- R1: After reset, `busy`, `sample` and `result_valid` are 0 and `result` is 0.
- R2: While idle, a rising edge of `convst` with `cs_n` low starts sampling, and `sample` reads 1 from the next cycle.
- R3: While idle, a falling edge of `cs_n` with `convst` high starts sampling.
- R4: While sampling, a falling edge of `convst` with `cs_n` low, or a falling edge of `cs_n` with `convst` low, ends sampling and starts a conversion. In the next cycle `sample` is 0 and `busy` is 1.
- R5: `busy` stays high for exactly WIDTH*STEP_CYCLES cycles in a conversion that is not aborted. It falls in the same cycle that the new result appears.
- R6: Bits are decided MSB first, one per step of STEP_CYCLES cycles. `cmp` is sampled in the last cycle of each step: 1 keeps the trial bit and 0 clears it. The result is therefore the `cmp` sequence read as a straight-binary word, in which 0x800 is midscale and 0xFFF is full scale minus one LSB.
- R7: While `busy` is high, a falling edge of `cs_n` with `convst` high aborts the conversion. In the next cycle `result` is 0xFE0, `result_valid` is 1, and both `busy` and `sample` are 0.
- R8: `result` changes only when a conversion completes or is aborted. `result_valid` is a one-cycle pulse at that moment, and the previous result stays on `result` while a conversion is in progress.
- R9: If a conversion completes while `cs_n` is low and `convst` is already high, sampling restarts at once, and `sample` is 1 in the cycle after `busy` falls.
- R10: Any edge that matches none of the conditions above leaves the state unchanged. Examples are a `convst` fall or a `cs_n` fall with `convst` low while idle, a `convst` fall with `cs_n` high while sampling, and a `convst` rise during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select (synchronous) |
| convst | input | 1 | Conversion-start strobe (synchronous) |
| cmp | input | 1 | Comparator decision: 1 keeps the current trial bit |
| busy | output | 1 | High while a conversion is in progress |
| sample | output | 1 | High while the input is being sampled |
| result | output | WIDTH | Last conversion result or abort marker |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
On every cycle the assertions check the following: an abort condition puts the marker code out together with a valid pulse, `result` moves only alongside a valid pulse, and that pulse never lasts two cycles. They also check that a conversion start turns sampling into busy, that a busy stretch never runs past its nominal length, and that idle stays idle when no start condition holds. Only the bench scenarios can show that the bit sequence produces the right word, that busy lasts exactly the full length, and that the chip-select-driven path and the back-to-back restart work. The same applies to the specific ignored edges and to the result being held while a conversion runs.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 12,
  parameter int STEP_CYCLES = 1,
  parameter logic [WIDTH-1:0] ABORT_CODE = 'hFE0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             convst,
  input  logic             cmp,
  output logic             busy,
  output logic             sample,
  output logic [WIDTH-1:0] result,
  output logic             result_valid
);
  localparam int IW = $clog2(WIDTH);
  localparam int SW = $clog2(STEP_CYCLES) + 1;
  localparam int CONV_CYCLES = WIDTH * STEP_CYCLES;
  localparam int BW = $clog2(CONV_CYCLES + 2) + 1;

  typedef enum logic [1:0] {IDLE, SAMP, CONV} st_t;
  st_t st;

  logic cs_q, cv_q;
  logic [WIDTH-1:0] acc;
  logic [IW-1:0] idx;
  logic [SW-1:0] cnt;

  wire cs_fall = cs_q & ~cs_n;
  wire cv_rise = convst & ~cv_q;
  wire cv_fall = cv_q & ~convst;
  wire samp_go = (cv_rise & ~cs_n) | (cs_fall & convst);
  wire conv_go = (cv_fall & ~cs_n) | (cs_fall & ~convst);
  wire abort   = cs_fall & convst;
  wire step_end = (cnt == SW'(STEP_CYCLES - 1));

  assign busy   = (st == CONV);
  assign sample = (st == SAMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cs_q <= 1'b1;
      cv_q <= 1'b0;
      acc <= '0;
      idx <= '0;
      cnt <= '0;
      result <= '0;
      result_valid <= 1'b0;
    end else begin
      cs_q <= cs_n;
      cv_q <= convst;
      result_valid <= 1'b0;
      case (st)
        IDLE: if (samp_go) st <= SAMP;
        SAMP: if (conv_go) begin
          st  <= CONV;
          acc <= {1'b1, {(WIDTH-1){1'b0}}};
          idx <= IW'(WIDTH - 1);
          cnt <= '0;
        end
        CONV: begin
          if (abort) begin
            st <= IDLE;
            result <= ABORT_CODE;
            result_valid <= 1'b1;
          end else if (step_end) begin
            cnt <= '0;
            acc[idx] <= cmp;
            if (idx == '0) begin
              result <= {acc[WIDTH-1:1], cmp};
              result_valid <= 1'b1;
              st <= (~cs_n & convst) ? SAMP : IDLE;
            end else begin
              acc[idx - IW'(1)] <= 1'b1;
              idx <= idx - IW'(1);
            end
          end else begin
            cnt <= cnt + SW'(1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [BW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + BW'(1);
    else busy_len <= '0;
  end

  AST_ABORT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_fall && convst) |=> (result == ABORT_CODE && result_valid && !busy)); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (result_valid || $stable(result))); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && conv_go) |=> (busy && !sample)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= BW'(CONV_CYCLES)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sample && !samp_go) |=> (!busy && !sample)); // R10
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic convst = 1'b0;
  logic cmp = 1'b0;
  logic busy, sample, result_valid;
  logic [11:0] result;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sar_seq u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst(convst), .cmp(cmp),
              .busy(busy), .sample(sample), .result(result), .result_valid(result_valid));

  localparam logic [11:0] VEC [6] = '{12'h800, 12'hFFF, 12'h000, 12'hA5A, 12'h7FF, 12'h001};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called right after the negedge at which the conversion-start edge was driven.
  task automatic feed(input logic [11:0] pat, input logic [11:0] prev, input bit b2b);
    int nbusy = 0;
    for (int i = 11; i >= 0; i--) begin
      @(negedge clk);
      if (i == 11) begin
        chk("R4", "busy after start", busy, 1);
        chk("R4", "sample after start", sample, 0);
      end
      if (i == 5) chk("R8", "result held mid-conversion", result, prev);
      if (b2b && i == 8) convst = 1'b1;
      nbusy += busy;
      cmp = pat[i];
    end
    @(negedge clk);
    chk("R5", "busy cycle count", nbusy, 12);
    chk("R5", "busy low at end", busy, 0);
    chk("R6", "result word", result, pat);
    chk("R8", "valid pulse", result_valid, 1);
    if (b2b) chk("R9", "auto resample", sample, 1);
    else chk("R9", "no resample", sample, 0);
    @(negedge clk);
    chk("R8", "valid one cycle", result_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "sample", sample, 0);
    chk("R1", "valid", result_valid, 0);
    chk("R1", "result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    prev = 12'h000;

    foreach (VEC[k]) begin
      convst = 1'b1;
      @(negedge clk);
      chk("R2", "sample on convst rise", sample, 1);
      convst = 1'b0;
      feed(VEC[k], prev, 1'b0);
      prev = VEC[k];
    end

    // R10: idle ignores convst fall-free cs fall with convst low
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "idle ignores cs fall convst low", {busy, sample}, 2'b00);

    // R3 and R10: chip-select driven start
    cs_n = 1'b1; convst = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R3", "sample on cs fall", sample, 1);
    cs_n = 1'b1;
    @(negedge clk);
    convst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "convst fall with cs high ignored", {busy, sample}, 2'b01);
    cs_n = 1'b0;
    feed(12'h3C6, prev, 1'b0);
    prev = 12'h3C6;

    // R9: back-to-back restart, then a second conversion from it
    convst = 1'b1;
    @(negedge clk);
    convst = 1'b0;
    feed(12'h9E1, prev, 1'b1);
    prev = 12'h9E1;
    chk("R9", "still sampling", sample, 1);
    convst = 1'b0;
    feed(12'h5B4, prev, 1'b0);

    // R7: abort, with convst rise during busy ignored (R10)
    convst = 1'b1;
    @(negedge clk);
    convst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1; convst = 1'b1;
    @(negedge clk);
    chk("R10", "convst rise during busy ignored", busy, 1);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R7", "abort marker", result, 12'hFE0);
    chk("R7", "abort valid", result_valid, 1);
    chk("R7", "abort idle", {busy, sample}, 2'b00);
    convst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "idle ignores convst fall", {busy, sample}, 2'b00);
    chk("R8", "marker held", result, 12'hFE0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule